// File: doc/BRIEF.md
# Edge-Sensitive External Interrupt Port

This block turns up to seven external pins into interrupt requests for a downstream interrupt controller. Pins are numbered 1 to 7; position 0 is reserved in every register and always reads back as zero. Each pin is first passed through a two-stage synchronizer. It then goes through a detector that can be programmed to follow the pin's low level or to latch a rising edge, a falling edge or either edge.

Software works through a small word-wide register port that is read combinationally and written on the clock edge. The port holds four registers. The sensitivity register is 16 bits wide and gives two bits to each pin. The direction register selects input or output for each pin. The enable register gates each pin's flag onto its request line. The flag register shows the pending flags, and writing a 1 to a flag bit clears that flag. A request line is high while its pin's flag is set and its enable bit is 1.

Top module: `edge_port_irq`

## Requirements
- R1: After reset, every register reads zero and every request output is low. This means every pin is level sensed, configured as an input and disabled.
- R2: The registers sit at these addresses: sensitivity at 0, direction at 1, enable at 2 and flags at 3. Reads are combinational. Bit 0 of each 8-bit register and bits [1:0] of the sensitivity register are reserved: they ignore writes and read 0. Bits [15:8] of the 8-bit registers also read 0.
- R3: A change on a pin input reaches its flag on the third rising clock edge after the change, and not before.
- R4: With sensitivity code 00 (level), the pin's flag is set while the synchronized pin is low and clear while it is high. Writing 1 to that flag bit has no lasting effect.
- R5: With code 01, a rising edge on the synchronized pin sets the flag, and a falling edge does not.
- R6: With code 10, a falling edge sets the flag, and a rising edge does not.
- R7: With code 11, either edge sets the flag.
- R8: In an edge mode, the flag stays set until a 1 is written to its bit in the flag register. Writing 0 to the bit leaves the flag unchanged.
- R9: If a detected edge and a clear write land on the same clock edge, the flag ends up set.
- R10: Request output n equals flag n AND enable bit n. A flag is set and can be read even while its enable bit is 0.
- R11: Pin n's code sits in sensitivity bits [2n+1:2n]. Direction bit n drives pin_dir_o for pin n, where 1 means output and 0 means input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | External pin levels, pins 1..NUM_PINS |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 2*NUM_PINS+2 | Write data |
| reg_rdata_o | output | 2*NUM_PINS+2 | Read data for reg_addr_i |
| pin_dir_o | output | NUM_PINS | Direction bits, 1 = output |
| irq_o | output | NUM_PINS | Request lines, pins 1..NUM_PINS |

## Verification
The bench builds the block with its defaults: seven pins and a two-stage synchronizer. With these values the full 16-bit sensitivity register is used, so every code can be placed at the top field (pin 7) and at interior fields. Because the synchronizer latency is fixed at two, the bench can sample the flag one edge before and on the edge where it must first appear. That same fixed latency lets the bench land a clear write on exactly the edge where a detected edge sets the flag.

// File: rtl/eport_pkg.sv
package eport_pkg;
  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_SENSE = 2'd0;
  localparam logic [1:0] ADDR_DIR   = 2'd1;
  localparam logic [1:0] ADDR_EN    = 2'd2;
  localparam logic [1:0] ADDR_FLAG  = 2'd3;
endpackage

// File: rtl/eport_sync.sv
module eport_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= '0;
      else         stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eport_pin_detect.sv
module eport_pin_detect
  import eport_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e sense_i,
  input  logic   lvl_i,
  input  logic   clr_i,
  output logic   flag_o
);
  logic prev_q, flag_q, rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (sense_i)
      SENSE_RISE: hit = rise;
      SENSE_FALL: hit = fall;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (sense_i == SENSE_LEVEL) flag_q <= ~lvl_i;  // active-low level
      else if (hit)               flag_q <= 1'b1;    // edge beats clear
      else if (clr_i)             flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i != SENSE_LEVEL && hit) |=> flag_o);  // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i != SENSE_LEVEL && !hit && clr_i) |=> !flag_o);  // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i != SENSE_LEVEL && !clr_i && flag_o) |=> flag_o);  // R8
endmodule

// File: rtl/eport_regs.sv
module eport_regs
  import eport_pkg::*;
#(
  parameter int unsigned NUM_PINS = 7,
  localparam int unsigned DATA_W  = 2 * NUM_PINS + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_PINS:1] flag_i,
  output logic [DATA_W-1:0] sense_o,
  output logic [NUM_PINS:1] dir_o,
  output logic [NUM_PINS:1] en_o,
  output logic [NUM_PINS:1] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:2]  sense_q;
  logic [NUM_PINS:1]  dir_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      dir_q   <= '0;
      en_q    <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_SENSE: sense_q <= wdata_i[DATA_W-1:2];
        ADDR_DIR:   dir_q   <= wdata_i[NUM_PINS:1];
        ADDR_EN:    en_q    <= wdata_i[NUM_PINS:1];
        default:    ;
      endcase
    end
  end

  assign clr_o   = (wr_i && addr_i == ADDR_FLAG) ? wdata_i[NUM_PINS:1] : '0;
  assign sense_o = {sense_q, 2'b00};
  assign dir_o   = dir_q;
  assign en_o    = en_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_SENSE: rdata_o = {sense_q, 2'b00};
      ADDR_DIR:   rdata_o[NUM_PINS:1] = dir_q;
      ADDR_EN:    rdata_o[NUM_PINS:1] = en_q;
      default:    rdata_o[NUM_PINS:1] = flag_i;
    endcase
  end

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_EN) |=> en_q == $past(wdata_i[NUM_PINS:1]));  // R2
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_DIR) |=> $stable(dir_q));  // R2
endmodule

// File: rtl/edge_port_irq.sv
module edge_port_irq
  import eport_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_PINS:1]       pin_i,
  input  logic                    reg_wr_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [2*NUM_PINS+1:0]   reg_wdata_i,
  output logic [2*NUM_PINS+1:0]   reg_rdata_o,
  output logic [NUM_PINS:1]       pin_dir_o,
  output logic [NUM_PINS:1]       irq_o
);
  localparam int unsigned DATA_W = 2 * NUM_PINS + 2;

  logic [NUM_PINS:1] lvl, flag, en, clr;
  logic [DATA_W-1:0] sense;

  eport_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  eport_regs #(.NUM_PINS(NUM_PINS)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .flag_i (flag),
    .sense_o(sense),
    .dir_o  (pin_dir_o),
    .en_o   (en),
    .clr_o  (clr),
    .rdata_o(reg_rdata_o)
  );

  for (genvar n = 1; n <= NUM_PINS; n++) begin : g_pin
    eport_pin_detect i_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sense_i(sense_e'(sense[2*n+1:2*n])),
      .lvl_i  (lvl[n]),
      .clr_i  (clr[n]),
      .flag_o (flag[n])
    );
  end

  assign irq_o = flag & en;

  AST_IRQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_EN && reg_wdata_i[NUM_PINS:1] == '0) |=> irq_o == '0);  // R10
endmodule

// File: tb/test_edge_port_irq.sv
module test_edge_port_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:1]  pin_i = 7'h7F;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = 16'h0;
  logic [15:0] reg_rdata_o;
  logic [7:1]  pin_dir_o;
  logic [7:1]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  edge_port_irq i_edge_port_irq (
    .clk_i, .rst_ni, .pin_i, .reg_wr_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .pin_dir_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg zero", v, 16'h0);
    end
    chk("R1 irq low", {9'h0, irq_o}, 16'h0);
    cyc(6);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R2 sense reserved bits", v, 16'hFFFC);
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R2 dir readback", v, 16'h00FE);
    chk("R11 pin_dir_o", {9'h0, pin_dir_o}, 16'h007F);
    wr(2'd1, 16'h0014); chk("R11 pin_dir_o pattern", {9'h0, pin_dir_o}, 16'h000A);
    wr(2'd2, 16'hFFFF); rd(2'd2, v); chk("R2 en readback", v, 16'h00FE);
    wr(2'd0, 16'h0); wr(2'd1, 16'h0); wr(2'd2, 16'h0);
  endtask

  task automatic t_level;
    logic [15:0] v;
    wr(2'd2, 16'h0008);
    pin_i[3] = 1'b0;
    cyc(2); chk("R3 not before third edge", {15'h0, irq_o[3]}, 16'h0);
    cyc(1); chk("R4 low sets irq (R3 third edge)", {15'h0, irq_o[3]}, 16'h1);
    wr(2'd3, 16'h0008); rd(2'd3, v); chk("R4 clear ignored in level", v & 16'h0008, 16'h0008);
    pin_i[3] = 1'b1;
    cyc(3); chk("R4 high clears irq", {15'h0, irq_o[3]}, 16'h0);
    wr(2'd2, 16'h0);
  endtask

  task automatic t_rise;
    logic [15:0] v;
    wr(2'd0, 16'h0010); wr(2'd2, 16'h0004);
    pin_i[2] = 1'b0; cyc(4);
    chk("R5 falling ignored", {15'h0, irq_o[2]}, 16'h0);
    pin_i[2] = 1'b1; cyc(3);
    chk("R5 rising sets", {15'h0, irq_o[2]}, 16'h1);
    pin_i[2] = 1'b0; cyc(4);
    chk("R8 sticky after pin falls", {15'h0, irq_o[2]}, 16'h1);
    wr(2'd3, 16'h00FB); rd(2'd3, v);
    chk("R8 write 0 no effect", v & 16'h0004, 16'h0004);
    wr(2'd3, 16'h0004); rd(2'd3, v);
    chk("R8 write 1 clears", v & 16'h0004, 16'h0);
    pin_i[2] = 1'b1; cyc(4); wr(2'd3, 16'h0004);
  endtask

  task automatic t_fall;
    logic [15:0] v;
    wr(2'd0, 16'h0800); wr(2'd2, 16'h0020);
    pin_i[5] = 1'b0;
    cyc(2); chk("R3 edge latency", {15'h0, irq_o[5]}, 16'h0);
    cyc(1); chk("R6 falling sets", {15'h0, irq_o[5]}, 16'h1);
    wr(2'd3, 16'h0020);
    pin_i[5] = 1'b1; cyc(4);
    rd(2'd3, v); chk("R6 rising ignored", v & 16'h0020, 16'h0);
  endtask

  task automatic t_both;
    wr(2'd0, 16'hC000); wr(2'd2, 16'h0080);
    pin_i[7] = 1'b0; cyc(3);
    chk("R7 falling sets", {15'h0, irq_o[7]}, 16'h1);
    wr(2'd3, 16'h0080);
    chk("R7 cleared", {15'h0, irq_o[7]}, 16'h0);
    pin_i[7] = 1'b1; cyc(3);
    chk("R7 rising sets", {15'h0, irq_o[7]}, 16'h1);
    wr(2'd3, 16'h0080);
  endtask

  task automatic t_gate;
    logic [15:0] v;
    wr(2'd0, 16'h1000); wr(2'd2, 16'h0);
    pin_i[6] = 1'b0; cyc(4); wr(2'd3, 16'h0040);
    pin_i[6] = 1'b1; cyc(3);
    rd(2'd3, v); chk("R10 flag set while disabled", v & 16'h0040, 16'h0040);
    chk("R10 irq gated", {9'h0, irq_o}, 16'h0);
    wr(2'd2, 16'h0040);
    chk("R10 irq on enable", {9'h0, irq_o}, 16'h0020);
    wr(2'd3, 16'h0040); wr(2'd2, 16'h0);
  endtask

  task automatic t_race;
    logic [15:0] v;
    wr(2'd0, 16'h0100);
    pin_i[4] = 1'b0; cyc(4); wr(2'd3, 16'h0010);
    pin_i[4] = 1'b1;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    wr(2'd3, 16'h0010);  // lands on third edge
    rd(2'd3, v); chk("R9 edge beats clear", v & 16'h0010, 16'h0010);
    wr(2'd3, 16'h0010); rd(2'd3, v);
    chk("R9 later clear works", v & 16'h0010, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_gate();
    t_race();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule